// File: doc/BRIEF.md
# Triangle Down-Spread Offset Generator

This block produces the time-varying fractional offset that a fractional-N feedback divider adds to its nominal divide ratio to spread a 100 MHz clock downward with a triangular profile. It runs from the 25 MHz reference clock. Each modulation period is 781 reference cycles long, about 32.01 kHz. The offset starts at zero, which is the nominal frequency. It falls linearly to the selected depth over 390 cycles, then climbs linearly back to zero over the remaining 391 cycles.

The offset is a signed word in units of 2^-24 of the nominal divide ratio. Two depths are available: 0.35 % (peak magnitude 58720) and 0.5 % (peak magnitude 83886). Each ramp is built by adding an integer step plus a fractional remainder, so the peak is reached exactly and no error builds up. The spread enable and the depth select take effect only at a period boundary, so a ramp never jumps partway through. A one-cycle strobe marks the first cycle of every period.

Top module: `ssc_tri_gen`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `strobe_o` is 1 and `offset_o` is 0. The first period after reset runs with spread disabled.
- R2: `strobe_o` is high for exactly one cycle in every 781 cycles. That cycle is period cycle k = 0, and `offset_o` is 0 in it.
- R3: When spread is enabled with peak magnitude P, period cycles k = 0..390 give `offset_o` = -floor(P*k/390).
- R4: At k = 390, `offset_o` equals -P exactly. P is 58720 when the depth select is 0 and 83886 when it is 1.
- R5: When spread is enabled, period cycles k = 391..780 give `offset_o` = -(P - floor(P*(k-390)/391)).
- R6: `offset_o` is never positive and never below -83886.
- R7: Between any two adjacent cycles, `offset_o` changes by at most floor(83886/390)+1 = 216.
- R8: When the enable captured for a period is 0, `offset_o` stays 0 for the whole period.
- R9: Enable and depth select are captured only at the clock edge that moves the block from cycle k = 780 to k = 0. Changes at any other time have no effect on `offset_o` until the next such edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, 25 MHz |
| rst | input | 1 | Synchronous reset, active high |
| spread_en_i | input | 1 | 1 enables the down-spread |
| depth_sel_i | input | 1 | 0 selects 0.35 %, 1 selects 0.5 % |
| offset_o | output | 24 | Signed divide-ratio offset, in units of 2^-24 |
| strobe_o | output | 1 | High in the first cycle of each period |

## Verification
The bench first runs four directed periods: spread off after reset, shallow depth, deep depth with the select flipped partway through, and an enabled period turned off at the boundary. Together they separate the two peak values, check that the ramp shape does not depend on the depth, and show that mid-period changes are ignored. Six further periods use random settings and random input flips at random cycles. These catch any leak of the live inputs into the offset and any error in the boundary capture. Every cycle is compared with the closed-form floor expressions, which exposes off-by-one errors in the remainder carry, in the turning point and in the wrap back to zero.

// File: rtl/ssc_tri_pkg.sv
package ssc_tri_pkg;

   typedef enum logic {
      RAMP_DOWN = 1'b0,
      RAMP_UP   = 1'b1
   } ramp_dir_t;

endpackage

// File: rtl/ssc_phase_ctr.sv
module ssc_phase_ctr
   import ssc_tri_pkg::*;
#(
   parameter int PERIOD = 781,
   parameter int DOWN   = 390,
   localparam int PH_W  = $clog2(PERIOD)
) (
   input  logic            clk,
   input  logic            rst,
   output logic [PH_W-1:0] phase_o,
   output logic            start_o,
   output logic            turn_o,
   output logic            wrap_o,
   output ramp_dir_t       dir_o
);

   generate
      if (DOWN < 1 || DOWN >= PERIOD - 1) begin : g_bad_split
         $error("ssc_phase_ctr: DOWN must lie strictly inside the period");
      end
   endgenerate

   logic [PH_W-1:0] phase_q;

   always_ff @(posedge clk) begin
      if (rst)         phase_q <= '0;
      else if (wrap_o) phase_q <= '0;
      else             phase_q <= phase_q + 1'b1;
   end

   assign phase_o = phase_q;
   assign start_o = (phase_q == '0);
   assign turn_o  = (phase_q == PH_W'(DOWN));
   assign wrap_o  = (phase_q == PH_W'(PERIOD - 1));
   assign dir_o   = (phase_q > PH_W'(DOWN)) ? RAMP_UP : RAMP_DOWN;

   // R2: the period start lasts a single cycle
   p_start_single_r2: assert property (@(posedge clk) disable iff (rst)
      start_o |=> !start_o);

   // R2: the end of one period is followed by the start of the next
   p_wrap_then_start_r2: assert property (@(posedge clk) disable iff (rst)
      wrap_o |=> start_o);

endmodule

// File: rtl/ssc_ramp_step.sv
module ssc_ramp_step #(
   parameter int MAG_W = 17,
   parameter int DIV_W = 9
) (
   input  logic [MAG_W-1:0] acc_i,
   input  logic [DIV_W-1:0] rem_i,
   input  logic [MAG_W-1:0] whole_i,
   input  logic [DIV_W-1:0] frac_i,
   input  logic [DIV_W-1:0] div_i,
   output logic [MAG_W-1:0] acc_o,
   output logic [DIV_W-1:0] rem_o
);

   logic [DIV_W:0] rem_sum;
   logic           carry;

   always_comb begin
      rem_sum = {1'b0, rem_i} + {1'b0, frac_i};
      carry   = (rem_sum >= {1'b0, div_i});
      rem_o   = carry ? DIV_W'(rem_sum - {1'b0, div_i}) : DIV_W'(rem_sum);
      acc_o   = acc_i + whole_i + MAG_W'(carry);
   end

endmodule

// File: rtl/ssc_tri_gen.sv
module ssc_tri_gen
   import ssc_tri_pkg::*;
#(
   parameter int PERIOD  = 781,
   parameter int DOWN    = 390,
   parameter int PEAK_LO = 58720,
   parameter int PEAK_HI = 83886,
   parameter int OUT_W   = 24
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    spread_en_i,
   input  logic                    depth_sel_i,
   output logic signed [OUT_W-1:0] offset_o,
   output logic                    strobe_o
);

   localparam int UP       = PERIOD - DOWN;
   localparam int PH_W     = $clog2(PERIOD);
   localparam int MAG_W    = $clog2(PEAK_HI + 1);
   localparam int DIV_W    = $clog2(UP + 1);
   localparam int STEP_MAX = PEAK_HI / DOWN + 1;

   generate
      if (PEAK_LO > PEAK_HI) begin : g_bad_order
         $error("ssc_tri_gen: PEAK_LO must not exceed PEAK_HI");
      end
      if (PEAK_HI >= (1 << (OUT_W - 1))) begin : g_bad_width
         $error("ssc_tri_gen: OUT_W too narrow for PEAK_HI");
      end
   endgenerate

   // per-depth step constants
   logic [MAG_W-1:0] peak_tab [2];
   logic [MAG_W-1:0] q_dn_tab [2];
   logic [MAG_W-1:0] q_up_tab [2];
   logic [DIV_W-1:0] r_dn_tab [2];
   logic [DIV_W-1:0] r_up_tab [2];

   for (genvar d = 0; d < 2; d++) begin : g_depth
      localparam int PK = (d == 0) ? PEAK_LO : PEAK_HI;
      assign peak_tab[d] = MAG_W'(PK);
      assign q_dn_tab[d] = MAG_W'(PK / DOWN);
      assign r_dn_tab[d] = DIV_W'(PK % DOWN);
      assign q_up_tab[d] = MAG_W'(PK / UP);
      assign r_up_tab[d] = DIV_W'(PK % UP);
   end

   logic [PH_W-1:0] phase;
   logic            start, turn, wrap;
   ramp_dir_t       dir;

   ssc_phase_ctr #(.PERIOD(PERIOD), .DOWN(DOWN)) ctr_i (
      .clk    (clk),
      .rst    (rst),
      .phase_o(phase),
      .start_o(start),
      .turn_o (turn),
      .wrap_o (wrap),
      .dir_o  (dir)
   );

   // R9: settings are captured only at the period boundary
   logic cfg_en, cfg_sel;
   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_en  <= 1'b0;
         cfg_sel <= 1'b0;
      end else if (wrap) begin
         cfg_en  <= spread_en_i;
         cfg_sel <= depth_sel_i;
      end
   end

   logic             use_up;
   logic [MAG_W-1:0] acc_q, acc_in, acc_nx, whole, peak;
   logic [DIV_W-1:0] rem_q, rem_in, rem_nx, frac, div;

   always_comb begin
      use_up = turn || (dir == RAMP_UP);
      acc_in = turn ? '0 : acc_q;
      rem_in = turn ? '0 : rem_q;
      whole  = use_up ? q_up_tab[cfg_sel] : q_dn_tab[cfg_sel];
      frac   = use_up ? r_up_tab[cfg_sel] : r_dn_tab[cfg_sel];
      div    = use_up ? DIV_W'(UP) : DIV_W'(DOWN);
      peak   = peak_tab[cfg_sel];
   end

   ssc_ramp_step #(.MAG_W(MAG_W), .DIV_W(DIV_W)) step_i (
      .acc_i  (acc_in),
      .rem_i  (rem_in),
      .whole_i(whole),
      .frac_i (frac),
      .div_i  (div),
      .acc_o  (acc_nx),
      .rem_o  (rem_nx)
   );

   always_ff @(posedge clk) begin
      if (rst || wrap) begin
         acc_q <= '0;
         rem_q <= '0;
      end else begin
         acc_q <= acc_nx;
         rem_q <= rem_nx;
      end
   end

   logic [MAG_W-1:0] mag;
   always_comb begin
      if (!cfg_en)               mag = '0;
      else if (dir == RAMP_DOWN) mag = acc_q;
      else                       mag = peak - acc_q;
   end

   assign offset_o = -$signed(OUT_W'(mag));
   assign strobe_o = start;

   // R6: never positive, never beyond the deepest peak
   p_range_r6: assert property (@(posedge clk) disable iff (rst)
      (offset_o <= 0) && (offset_o >= -$signed(OUT_W'(PEAK_HI))));

   // R2: every period starts from the nominal frequency
   p_start_zero_r2: assert property (@(posedge clk) disable iff (rst)
      strobe_o |-> (offset_o == 0));

   // R4: the turning point hits the selected peak exactly
   p_peak_exact_r4: assert property (@(posedge clk) disable iff (rst)
      (turn && cfg_en) |-> (acc_q == peak));

   // R7: bounded change between adjacent cycles
   p_slope_r7: assert property (@(posedge clk) disable iff (rst)
      ((mag >= $past(mag)) ? (mag - $past(mag)) : ($past(mag) - mag))
         <= MAG_W'(STEP_MAX));

   // R8: disabled periods stay at nominal
   p_off_zero_r8: assert property (@(posedge clk) disable iff (rst)
      !cfg_en |-> (offset_o == 0));

   // R9: captured settings hold for the whole period
   p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !strobe_o |-> ($stable(cfg_en) && $stable(cfg_sel)));

endmodule

// File: tb/ssc_tri_gen_tb.sv
module ssc_tri_gen_tb_top;

   localparam int CLK_PERIOD = 40;
   localparam int PERIOD     = 781;
   localparam int DOWN       = 390;
   localparam int UP         = PERIOD - DOWN;
   localparam int PEAK_LO    = 58720;
   localparam int PEAK_HI    = 83886;
   localparam int STEP_MAX   = PEAK_HI / DOWN + 1;
   localparam int NPER       = 10;

   logic               clk = 1'b0;
   logic               rst;
   logic               en, sel;
   logic signed [23:0] offset;
   logic               strobe;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ssc_tri_gen dut_i (
      .clk        (clk),
      .rst        (rst),
      .spread_en_i(en),
      .depth_sel_i(sel),
      .offset_o   (offset),
      .strobe_o   (strobe)
   );

   function automatic longint exp_mag(int k, bit e, bit s);
      longint p;
      p = s ? PEAK_HI : PEAK_LO;
      if (!e)            return 0;
      else if (k <= DOWN) return (p * k) / DOWN;
      else               return p - (p * (k - DOWN)) / UP;
   endfunction

   task automatic chk(bit ok, string tag, longint act, longint expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      int  k;
      bit  men, msel, flipped, first;
      longint prev, e;
      string tag;
      void'($urandom(32'd20240611));
      rst = 1'b1; en = 1'b1; sel = 1'b1;
      k = 0; men = 0; msel = 0; flipped = 0; first = 1; prev = 0;
      repeat (4) @(negedge clk);
      // R1: reset state seen while reset is still high
      chk(strobe == 1'b1, "R1", strobe, 1);
      chk(offset == 0, "R1", offset, 0);
      rst = 1'b0;
      for (int cyc = 0; cyc < NPER * PERIOD; cyc++) begin
         int per;
         per = cyc / PERIOD;
         e = exp_mag(k, men, msel);
         if (first) begin
            chk(strobe == 1'b1 && offset == 0, "R1", offset, 0);
         end
         if (!men)            tag = "R8";
         else if (flipped)    tag = "R9";
         else if (k == DOWN)  tag = "R4";
         else if (k < DOWN)   tag = "R3";
         else                 tag = "R5";
         chk(offset == -e, tag, offset, -e);
         chk(strobe == (k == 0), "R2", strobe, (k == 0));
         chk(offset <= 0 && offset >= -PEAK_HI, "R6", offset, 0);
         if (!first) begin
            longint d;
            d = (offset > prev) ? offset - prev : prev - offset;
            chk(d <= STEP_MAX, "R7", d, STEP_MAX);
         end
         prev  = offset;
         first = 0;
         // stimulus for the coming edge
         if (k == PERIOD - 1) begin
            case (per + 1)
               1: begin en = 1; sel = 0; end
               2: begin en = 1; sel = 1; end
               3: begin en = 0; sel = 1; end
               default: begin
                  en  = ($urandom_range(0, 3) != 0);
                  sel = $urandom_range(0, 1) != 0;
               end
            endcase
            flipped = 0;
         end else if (per == 2 && k == 200) begin
            sel = ~sel; en = ~en;   // R9 directed mid-period change
            flipped = 1;
         end else if (per >= 4 && $urandom_range(0, 149) == 0) begin
            if ($urandom_range(0, 1) != 0) en = ~en;
            else                          sel = ~sel;
            flipped = 1;
         end
         if (k == PERIOD - 1) begin
            k = 0; men = en; msel = sel;
         end else begin
            k++;
         end
         @(negedge clk);
      end
      finish_run();
   end

endmodule